// File: doc/BRIEF.md
# Shared Lane Budget Arbiter

This block decides whether a display pipe may have the serial-link lanes it needs, when up to three pipes draw on one pool of lanes. After a `start` pulse it works out how many lanes the pipe needs from the pixel clock, the pixel bit depth and the per-lane link bandwidth. An iterative divider does this division. The block then checks the lane count against admission rules that depend on two straps and on what the other pipes are using. Pipes B and C have asymmetric rules that depend on each other.

When a request does not fit and the bit depth is still above 18, the block lowers the depth by 6, marks the result as bandwidth-constrained and computes the lane count again. When the depth reaches the floor with the request still refused, the result is a final failure. On a grant for pipe B or pipe C, the block updates a lane-split select that steers the shared lanes. The select is frozen while either of those pipes has its receiver running. Every result arrives with a single-cycle `done` pulse and holds until the next evaluation.

Top module: `lane_budget_arbiter`

## Requirements
- R1: The lane count is ceil(pixClk·bpp·21 / (linkBw·160)). `lanesOut` reports it saturated at 7, and a link bandwidth of 0 gives 7.
- R2: A lane count above 4 is never granted.
- R3: With `narrowMode`=1, a lane count of 2 or fewer is granted and anything above 2 is refused.
- R4: With `narrowMode`=0 and `threePipeMode`=0, every lane count of 4 or fewer is granted.
- R5: In three-pipe mode, pipe A (`pipeSel`=0, and also 3) is always granted at 4 or fewer lanes. Pipe B (`pipeSel`=1) is granted if it needs 2 or fewer lanes, or if pipe C needs none.
- R6: In three-pipe mode, pipe C (`pipeSel`=2) is refused if it needs more than 2 lanes or if pipe B needs more than 2. A peer pipe needs zero lanes when its enable or its encoder-present input is low, and otherwise it needs its `peerLanes` value.
- R7: A refusal at a bit depth above 18 lowers the depth by 6, sets `bwConstrained` and retries. A grant reached after one or more steps reports `recompute`=1 instead of a plain grant.
- R8: A refusal at a bit depth of 18 or below ends with `failed`=1 and `granted`=0, and `bppOut` holds the last depth tried.
- R9: `splitSel` resets to 0. A grant for pipe B sets it to 1 when B needs 2 or fewer lanes and to 0 otherwise. A grant for pipe C sets it to 1. Pipe A and refused requests leave it unchanged, and it never changes while `rxActiveB` or `rxActiveC` is high.
- R10: After reset, `done`, `granted`, `failed`, `recompute` and `bwConstrained` are 0. `done` is high for exactly one cycle per evaluation, and the results hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation (taken when idle) |
| pipeSel | input | 2 | Requesting pipe: 0=A, 1=B, 2=C |
| bppIn | input | BPP_W | Starting bits per pixel |
| pixClk | input | PCLK_W | Pixel clock |
| linkBw | input | LBW_W | Per-lane link bandwidth, same unit as pixClk |
| threePipeMode | input | 1 | 1 = three pipes share the lanes |
| narrowMode | input | 1 | 1 = at most 2 lanes for any pipe |
| peerEnB | input | 1 | Pipe B enabled |
| peerEncB | input | 1 | Pipe B has a bridge-side encoder |
| peerLanesB | input | 3 | Lanes configured on pipe B |
| peerEnC | input | 1 | Pipe C enabled |
| peerEncC | input | 1 | Pipe C has a bridge-side encoder |
| peerLanesC | input | 3 | Lanes configured on pipe C |
| rxActiveB | input | 1 | Pipe B receiver running |
| rxActiveC | input | 1 | Pipe C receiver running |
| done | output | 1 | One-cycle result strobe |
| granted | output | 1 | Request admitted |
| failed | output | 1 | Refused at the depth floor |
| recompute | output | 1 | Grant needed a depth reduction |
| bwConstrained | output | 1 | Depth was reduced |
| bppOut | output | BPP_W | Final bit depth |
| lanesOut | output | 3 | Final lane count (saturated) |
| splitSel | output | 1 | Lane-split select |

## Verification
The assertions check on every cycle that a lane count above 4, or above 2 in narrow mode, is never committed as a grant. They also check that each depth step subtracts exactly 6 and raises the constrained flag, that a failure reports a depth at or below the floor, that the split select holds while a receiver is running, and that `done` never lasts two cycles. Only the bench scenarios can show that the computed lane count is right, that the cross-coupled pipe B and pipe C rules and the peer zero-need cases decide correctly, that multi-step fallback chains end at the right depth, and that the select takes the right value after a grant.

// File: rtl/lba_pkg.sv
package lba_pkg;
  localparam int MIN_BPP      = 18;
  localparam int BPP_STEP     = 6;
  localparam int MAX_LANES    = 4;
  localparam int NARROW_LANES = 2;

  typedef struct packed {
    logic loadReq;   // capture starting depth, clear flags
    logic divStart;  // launch lane-count division
    logic stepDown;  // lower depth and retry
    logic commit;    // register verdict and pulse done
  } lbaStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_LOAD, ST_RUN, ST_DECIDE
  } lbaState_t;
endpackage

// File: rtl/lba_div.sv
module lba_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             divDone
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quotR;
  logic [DEN_W-1:0] remR;
  logic [CNT_W-1:0] cnt;
  logic             doneR;
  logic [DEN_W:0]   remSh;
  logic [DEN_W:0]   remNext;
  logic             geBit;

  always_comb begin
    remSh   = {remR, quotR[NUM_W-1]};
    geBit   = (remSh >= {1'b0, den});
    remNext = geBit ? (remSh - {1'b0, den}) : remSh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotR <= '0;
      remR  <= '0;
      cnt   <= '0;
      doneR <= 1'b0;
    end else if (start) begin
      quotR <= num;
      remR  <= '0;
      cnt   <= CNT_W'(NUM_W);
      doneR <= 1'b0;
    end else if (cnt != '0) begin
      quotR <= {quotR[NUM_W-2:0], geBit};
      remR  <= remNext[DEN_W-1:0];
      cnt   <= cnt - 1'b1;
      doneR <= (cnt == CNT_W'(1));
    end else begin
      doneR <= 1'b0;
    end
  end

  assign quot    = quotR;
  assign divDone = doneR;

  a_r1_div_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    doneR |=> !doneR);
endmodule

// File: rtl/lba_ctrl.sv
module lba_ctrl
  import lba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       divDone,
  input  logic       fits,
  input  logic       canStep,
  output lbaStrobe_t stb
);
  lbaState_t state, stateNext;

  always_comb begin
    stb          = '0;
    stateNext    = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.loadReq = 1'b1;
        stateNext   = ST_LOAD;
      end
      ST_LOAD: begin
        stb.divStart = 1'b1;
        stateNext    = ST_RUN;
      end
      ST_RUN: if (divDone) stateNext = ST_DECIDE;
      ST_DECIDE: begin
        if (!fits && canStep) begin
          stb.stepDown = 1'b1;
          stateNext    = ST_LOAD;
        end else begin
          stb.commit = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
endmodule

// File: rtl/lba_dpath.sv
module lba_dpath
  import lba_pkg::*;
#(
  parameter int BPP_W  = 6,
  parameter int PCLK_W = 20,
  parameter int LBW_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lbaStrobe_t        stb,
  input  logic [1:0]        pipeSel,
  input  logic [BPP_W-1:0]  bppIn,
  input  logic [PCLK_W-1:0] pixClk,
  input  logic [LBW_W-1:0]  linkBw,
  input  logic              threePipeMode,
  input  logic              narrowMode,
  input  logic              peerEnB,
  input  logic              peerEncB,
  input  logic [2:0]        peerLanesB,
  input  logic              peerEnC,
  input  logic              peerEncC,
  input  logic [2:0]        peerLanesC,
  input  logic              rxActiveB,
  input  logic              rxActiveC,
  output logic              divDone,
  output logic              fits,
  output logic              canStep,
  output logic              done,
  output logic              granted,
  output logic              failed,
  output logic              recompute,
  output logic              bwConstrained,
  output logic [BPP_W-1:0]  bppOut,
  output logic [2:0]        lanesOut,
  output logic              splitSel
);
  localparam int NUM_W = PCLK_W + BPP_W + 6;
  localparam int DEN_W = LBW_W + 8;

  logic [BPP_W-1:0] bppReg;
  logic             bwFlag;
  logic [NUM_W-1:0] numAdj, quot;
  logic [DEN_W-1:0] den;
  logic [2:0]       lanesSat, needB, needC;
  logic             doneQ, grantQ, failQ, recompQ, splitQ;
  logic [2:0]       lanesQ;

  assign den    = DEN_W'(linkBw) * DEN_W'(160);
  assign numAdj = NUM_W'(pixClk) * NUM_W'(bppReg) * NUM_W'(21) + NUM_W'(den) - NUM_W'(1);

  lba_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(stb.divStart),
    .num(numAdj), .den(den), .quot(quot), .divDone(divDone)
  );

  assign lanesSat = (|quot[NUM_W-1:3]) ? 3'd7 : quot[2:0];
  assign needB    = (peerEnB && peerEncB) ? peerLanesB : 3'd0;
  assign needC    = (peerEnC && peerEncC) ? peerLanesC : 3'd0;
  assign canStep  = (bppReg > BPP_W'(MIN_BPP));

  always_comb begin
    if (lanesSat > 3'(MAX_LANES))  fits = 1'b0;
    else if (narrowMode)           fits = (lanesSat <= 3'(NARROW_LANES));
    else if (!threePipeMode)       fits = 1'b1;
    else begin
      case (pipeSel)
        2'd1:    fits = (lanesSat <= 3'(NARROW_LANES)) || (needC == 3'd0);
        2'd2:    fits = (lanesSat <= 3'(NARROW_LANES)) && (needB <= 3'(NARROW_LANES));
        default: fits = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bppReg <= '0;
      bwFlag <= 1'b0;
    end else if (stb.loadReq) begin
      bppReg <= bppIn;
      bwFlag <= 1'b0;
    end else if (stb.stepDown) begin
      bppReg <= bppReg - BPP_W'(BPP_STEP);
      bwFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneQ   <= 1'b0;
      grantQ  <= 1'b0;
      failQ   <= 1'b0;
      recompQ <= 1'b0;
      lanesQ  <= '0;
      splitQ  <= 1'b0;
    end else begin
      doneQ <= stb.commit;
      if (stb.commit) begin
        grantQ  <= fits;
        failQ   <= !fits;
        recompQ <= fits && bwFlag;
        lanesQ  <= lanesSat;
        if (fits && !rxActiveB && !rxActiveC) begin
          if (pipeSel == 2'd1)      splitQ <= (lanesSat <= 3'(NARROW_LANES));
          else if (pipeSel == 2'd2) splitQ <= 1'b1;
        end
      end
    end
  end

  assign done          = doneQ;
  assign granted       = grantQ;
  assign failed        = failQ;
  assign recompute     = recompQ;
  assign bwConstrained = bwFlag;
  assign bppOut        = bppReg;
  assign lanesOut      = lanesQ;
  assign splitSel      = splitQ;

  a_r2_no_wide_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.commit && lanesSat > 3'(MAX_LANES)) |=> !grantQ);
  a_r3_narrow_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.commit && narrowMode && lanesSat > 3'(NARROW_LANES)) |=> !grantQ);
  a_r7_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    stb.stepDown |=> (bwFlag && bppReg == $past(bppReg) - BPP_W'(BPP_STEP)));
  a_r7_step_guard: assert property (@(posedge clk) disable iff (!rst_n)
    stb.stepDown |-> bppReg > BPP_W'(MIN_BPP));
  a_r8_fail_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (doneQ && failQ) |-> bppReg <= BPP_W'(MIN_BPP));
  a_r9_split_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rxActiveB || rxActiveC) |=> $stable(splitQ));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |=> !doneQ);
endmodule

// File: rtl/lane_budget_arbiter.sv
module lane_budget_arbiter
  import lba_pkg::*;
#(
  parameter int BPP_W  = 6,
  parameter int PCLK_W = 20,
  parameter int LBW_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        pipeSel,
  input  logic [BPP_W-1:0]  bppIn,
  input  logic [PCLK_W-1:0] pixClk,
  input  logic [LBW_W-1:0]  linkBw,
  input  logic              threePipeMode,
  input  logic              narrowMode,
  input  logic              peerEnB,
  input  logic              peerEncB,
  input  logic [2:0]        peerLanesB,
  input  logic              peerEnC,
  input  logic              peerEncC,
  input  logic [2:0]        peerLanesC,
  input  logic              rxActiveB,
  input  logic              rxActiveC,
  output logic              done,
  output logic              granted,
  output logic              failed,
  output logic              recompute,
  output logic              bwConstrained,
  output logic [BPP_W-1:0]  bppOut,
  output logic [2:0]        lanesOut,
  output logic              splitSel
);
  lbaStrobe_t stb;
  logic divDone, fits, canStep;

  lba_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .divDone(divDone), .fits(fits), .canStep(canStep), .stb(stb)
  );

  lba_dpath #(.BPP_W(BPP_W), .PCLK_W(PCLK_W), .LBW_W(LBW_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .pipeSel(pipeSel), .bppIn(bppIn),
    .pixClk(pixClk), .linkBw(linkBw), .threePipeMode(threePipeMode),
    .narrowMode(narrowMode), .peerEnB(peerEnB), .peerEncB(peerEncB),
    .peerLanesB(peerLanesB), .peerEnC(peerEnC), .peerEncC(peerEncC),
    .peerLanesC(peerLanesC), .rxActiveB(rxActiveB), .rxActiveC(rxActiveC),
    .divDone(divDone), .fits(fits), .canStep(canStep), .done(done),
    .granted(granted), .failed(failed), .recompute(recompute),
    .bwConstrained(bwConstrained), .bppOut(bppOut), .lanesOut(lanesOut),
    .splitSel(splitSel)
  );
endmodule

// File: tb/sim_lane_budget_arbiter.sv
module sim_lane_budget_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  pipeSel = '0;
  logic [5:0]  bppIn = '0;
  logic [19:0] pixClk = '0, linkBw = '0;
  logic        threePipeMode = 1'b0, narrowMode = 1'b0;
  logic        peerEnB = 1'b0, peerEncB = 1'b0, peerEnC = 1'b0, peerEncC = 1'b0;
  logic [2:0]  peerLanesB = '0, peerLanesC = '0;
  logic        rxActiveB = 1'b0, rxActiveC = 1'b0;
  logic        done, granted, failed, recompute, bwConstrained, splitSel;
  logic [5:0]  bppOut;
  logic [2:0]  lanesOut;

  int nChecks = 0, nFails = 0;
  bit expSplit = 1'b0;

  always #2 clk = ~clk;

  lane_budget_arbiter u0 (.*);

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lanesOf(longint pc, longint bpp, longint bw);
    longint num, den, q;
    if (bw == 0) return 7;
    num = pc * bpp * 21;
    den = bw * 160;
    q = (num + den - 1) / den;
    return (q > 7) ? 7 : int'(q);
  endfunction

  function automatic bit fitsOf(int pipe, int ln, bit three, bit narrow, int nB, int nC);
    if (ln > 4) return 0;
    if (narrow) return ln <= 2;
    if (!three) return 1;
    if (pipe == 1) return (ln <= 2) || (nC == 0);
    if (pipe == 2) return (ln <= 2) && (nB <= 2);
    return 1;
  endfunction

  task automatic evaluate(string tag, int pipe, int pc, int bpp, int bw, bit three, bit narrow,
                          bit eB, bit cB, int lB, bit eC, bit cC, int lC, bit rxB, bit rxC);
    int curBpp = bpp, ln, nB, nC, waitCnt = 0;
    bit ok, stepped = 0;
    nB = (eB && cB) ? lB : 0;
    nC = (eC && cC) ? lC : 0;
    ln = lanesOf(pc, curBpp, bw);
    ok = fitsOf(pipe, ln, three, narrow, nB, nC);
    while (!ok && curBpp > 18) begin
      curBpp -= 6; stepped = 1;
      ln = lanesOf(pc, curBpp, bw);
      ok = fitsOf(pipe, ln, three, narrow, nB, nC);
    end
    if (ok && !rxB && !rxC) begin
      if (pipe == 1) expSplit = (ln <= 2);
      else if (pipe == 2) expSplit = 1'b1;
    end
    @(negedge clk);
    pipeSel = 2'(pipe); pixClk = 20'(pc); bppIn = 6'(bpp); linkBw = 20'(bw);
    threePipeMode = three; narrowMode = narrow;
    peerEnB = eB; peerEncB = cB; peerLanesB = 3'(lB);
    peerEnC = eC; peerEncC = cC; peerLanesC = 3'(lC);
    rxActiveB = rxB; rxActiveC = rxC; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waitCnt < 1000) begin @(negedge clk); waitCnt++; end
    chk({tag, " done seen"}, done, 1);
    chk({tag, " R1 lanes"}, lanesOut, ln);
    chk({tag, " granted"}, granted, ok);
    chk({tag, " R8 failed"}, failed, !ok);
    chk({tag, " R7 recompute"}, recompute, ok && stepped);
    chk({tag, " R7 bwConstrained"}, bwConstrained, stepped);
    chk({tag, " R7 bppOut"}, bppOut, curBpp);
    chk({tag, " R9 splitSel"}, splitSel, expSplit);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, done, 0);
    chk({tag, " R10 result held"}, granted, ok);
  endtask

  task automatic t_reset();
    chk("R10 reset done", done, 0);
    chk("R10 reset granted", granted, 0);
    chk("R10 reset failed", failed, 0);
    chk("R10 reset bwConstrained", bwConstrained, 0);
    chk("R9 reset splitSel", splitSel, 0);
  endtask

  task automatic t_two_pipe();
    evaluate("R4 C 1 lane", 2, 80000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 0,0);
    evaluate("R4 B 3 lanes", 1, 250000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 0,0);
  endtask

  task automatic t_fallback();
    evaluate("R2 R7 one step", 0, 350000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 0,0);
    evaluate("R7 two steps", 0, 350000, 30, 270000, 0, 0, 0,0,0, 0,0,0, 0,0);
    evaluate("R8 floor fail", 0, 500000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 0,0);
    evaluate("R1 R2 zero bw", 0, 1000, 24, 0, 0, 0, 0,0,0, 0,0,0, 0,0);
  endtask

  task automatic t_narrow();
    evaluate("R3 narrow 2", 0, 150000, 24, 270000, 0, 1, 0,0,0, 0,0,0, 0,0);
    evaluate("R3 narrow 3", 0, 250000, 24, 270000, 0, 1, 0,0,0, 0,0,0, 0,0);
  endtask

  task automatic t_three_pipe();
    evaluate("R5 A 4 lanes", 0, 350000, 18, 270000, 1, 0, 1,1,4, 1,1,2, 0,0);
    evaluate("R5 B 3 vs C busy", 1, 250000, 24, 270000, 1, 0, 0,0,0, 1,1,2, 0,0);
    evaluate("R5 B 3 C off", 1, 250000, 24, 270000, 1, 0, 0,0,0, 0,1,2, 0,0);
    evaluate("R6 B 3 C no enc", 1, 250000, 24, 270000, 1, 0, 0,0,0, 1,0,2, 0,0);
    evaluate("R6 C 2 vs B 3", 2, 150000, 24, 270000, 1, 0, 1,1,3, 0,0,0, 0,0);
    evaluate("R6 C 2 vs B 2", 2, 150000, 24, 270000, 1, 0, 1,1,2, 0,0,0, 0,0);
    evaluate("R6 C 3 lanes", 2, 250000, 24, 270000, 1, 0, 0,0,0, 0,0,0, 0,0);
  endtask

  task automatic t_split_hold();
    evaluate("R9 B 3 clears", 1, 250000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 0,0);
    evaluate("R9 hold rxB", 2, 80000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 1,0);
    evaluate("R9 hold rxC", 2, 80000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 0,1);
    evaluate("R9 released", 2, 80000, 24, 270000, 0, 0, 0,0,0, 0,0,0, 0,0);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_two_pipe();
    t_fallback();
    t_narrow();
    t_three_pipe();
    t_split_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule